// File: doc/BRIEF.md
# XT Keyboard Host Receiver

This block is the receiving end of a PC/XT style keyboard link, seen from the host. The keyboard drives both the clock and the data line. On each falling clock edge the block shifts the data line into a nine-bit register. A frame is a start one followed by eight data bits, least significant bit first. When the start one reaches the bottom of the register, the frame is complete. The block then presents the eight data bits together with a valid flag. In the same cycle it pulls both lines low, so the keyboard cannot send again until the system has taken the byte.

The system takes the byte with a one-cycle acknowledge. The acknowledge clears the register and the valid flag, and both lines are released on the next cycle. A frame whose bits stop arriving is dropped after a programmable idle time. A reset request holds the clock line low for a programmable number of cycles, which the keyboard treats as a reset. The keyboard then answers with its self-test byte, 0xAA, which arrives as a normal frame. Both incoming lines pass through a two-flop synchronizer before use.

Top module: `xt_host_rx`

## Requirements
- R1: After reset, byte_valid is 0, and both clk_drive_low and data_drive_low are 0.
- R2: A frame is a start bit of 1 followed by data bits D0 to D7, each sampled on a falling edge of the synchronized clock. After the ninth falling edge, byte_out equals D7..D0 (D0 in bit 0) and byte_valid is 1.
- R3: A single zero bit sent ahead of the start bit (ten falling edges in all) yields the same byte as a plain nine-bit frame.
- R4: In the cycle byte_valid rises, clk_drive_low and data_drive_low are both 1. Both stay 1 for as long as byte_valid is 1.
- R5: While byte_valid is 1, activity on either input line changes neither byte_out nor byte_valid.
- R6: An ack sampled while byte_valid is 1 drops byte_valid and both drive-low outputs on the next clock edge.
- R7: An ack sampled while byte_valid is 0 has no effect: a frame in progress completes with the correct byte.
- R8: A partial frame that sees no falling clock edge for TIMEOUT_CYC cycles is discarded. The next full frame is then received correctly.
- R9: A reset_req pulse holds clk_drive_low at 1 for exactly RESET_CYC cycles while data_drive_low stays 0. The pulse also clears a pending byte at the next edge, and reception resumes afterwards, so a following 0xAA frame is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kb_clk_in | input | 1 | Keyboard clock line as seen at the pin |
| kb_data_in | input | 1 | Keyboard data line as seen at the pin |
| ack | input | 1 | System has consumed byte_out |
| reset_req | input | 1 | One-cycle request to send a reset pulse to the keyboard |
| byte_out | output | 8 | Received byte |
| byte_valid | output | 1 | byte_out holds an unread byte |
| clk_drive_low | output | 1 | Pull the clock line low |
| data_drive_low | output | 1 | Pull the data line low |

## Verification
The bench sweeps all 256 byte values, sending every other one with a leading zero. A design with the bit order reversed, or one that tested completion at the wrong register position, would corrupt nearly every byte of that sweep. Clock activity is injected while a byte is pending; a receiver that kept shifting during holdoff would change the presented byte. A partial frame is stranded before the idle time and a stray ack is issued mid-frame; without the timeout or with an unqualified ack, the following byte would be misassembled. The reset pulse width is counted cycle by cycle, and a pending byte is shown to be dropped by the reset.

// File: rtl/xt_host_rx.sv
module xt_host_rx #(
  parameter int TIMEOUT_CYC = 100000,
  parameter int RESET_CYC   = 1000000,
  parameter int GUARD_CYC   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kb_clk_in,
  input  logic       kb_data_in,
  input  logic       ack,
  input  logic       reset_req,
  output logic [7:0] byte_out,
  output logic       byte_valid,
  output logic       clk_drive_low,
  output logic       data_drive_low
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int RW = $clog2(RESET_CYC + 1);
  localparam int GW = $clog2(GUARD_CYC + 1);

  logic [1:0]    c_s, d_s;
  logic          c_prev;
  logic [8:0]    sr;
  logic [TW-1:0] idle_cnt;
  logic [RW-1:0] rst_cnt;
  logic [GW-1:0] guard_cnt;

  wire fall      = c_prev & ~c_s[1];
  wire resetting = rst_cnt != '0;
  wire listen    = ~sr[0] & ~resetting & (guard_cnt == '0);
  wire consume   = sr[0] & ack;
  wire expired   = listen & (sr != '0) & (idle_cnt == TW'(TIMEOUT_CYC));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c_s    <= 2'b11;
      d_s    <= 2'b11;
      c_prev <= 1'b1;
    end else begin
      c_s    <= {c_s[0], kb_clk_in};
      d_s    <= {d_s[0], kb_data_in};
      c_prev <= c_s[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    sr <= '0;
    else if (reset_req | resetting) sr <= '0;
    else if (consume)              sr <= '0;
    else if (listen & fall)        sr <= {d_s[1], sr[8:1]};
    else if (expired)              sr <= '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            idle_cnt <= '0;
    else if (fall | ~listen | (sr == '0))  idle_cnt <= '0;
    else if (idle_cnt != TW'(TIMEOUT_CYC)) idle_cnt <= idle_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         rst_cnt <= '0;
    else if (reset_req) rst_cnt <= RW'(RESET_CYC);
    else if (resetting) rst_cnt <= rst_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                    guard_cnt <= '0;
    else if (consume | (rst_cnt == RW'(1) & ~reset_req)) guard_cnt <= GW'(GUARD_CYC);
    else if (guard_cnt != '0)                      guard_cnt <= guard_cnt - 1'b1;

  assign byte_out       = sr[8:1];
  assign byte_valid     = sr[0];
  assign clk_drive_low  = sr[0] | resetting;
  assign data_drive_low = sr[0];
endmodule

module xt_host_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack,
  input logic       reset_req,
  input logic [7:0] byte_out,
  input logic       byte_valid,
  input logic       clk_drive_low,
  input logic       data_drive_low
);
  assert_holdoff_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_valid) |-> clk_drive_low && data_drive_low);
  assert_hold_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !ack && !reset_req |=> byte_valid && $stable(byte_out));
  assert_ack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && ack && !reset_req |=> !byte_valid && !data_drive_low);
  assert_reset_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> clk_drive_low && !data_drive_low && !byte_valid);
  assert_valid_held_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> clk_drive_low);
endmodule

bind xt_host_rx xt_host_rx_chk u_chk (.*);

// File: tb/test_xt_host_rx.sv
module test_xt_host_rx;
  localparam int TO = 200, RC = 100, GC = 4, H = 10;
  logic clk = 0, rst_n = 0;
  logic kb_c = 1, kb_d = 1, ack = 0, reset_req = 0;
  logic ovr = 0, ovr_c = 1, ovr_d = 1;
  logic [7:0] byte_out;
  logic byte_valid, clk_drive_low, data_drive_low;
  logic kbc, kbd;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;
  assign kbc = ovr ? ovr_c : (kb_c & ~clk_drive_low);
  assign kbd = ovr ? ovr_d : (kb_d & ~data_drive_low);

  xt_host_rx #(.TIMEOUT_CYC(TO), .RESET_CYC(RC), .GUARD_CYC(GC)) i_xt_host_rx (
    .clk(clk), .rst_n(rst_n), .kb_clk_in(kbc), .kb_data_in(kbd), .ack(ack),
    .reset_req(reset_req), .byte_out(byte_out), .byte_valid(byte_valid),
    .clk_drive_low(clk_drive_low), .data_drive_low(data_drive_low));

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [9:0] bits, int from, int to);
    for (int i = from; i <= to; i++) begin
      kb_d = bits[i];
      cyc(H);
      kb_c = 0;
      cyc(H);
      kb_c = 1;
    end
    kb_d = 1;
  endtask

  task automatic send_frame(logic [7:0] v, bit pseudo);
    if (pseudo) send_bits({v, 1'b1, 1'b0}, 0, 9);
    else        send_bits({1'b0, v, 1'b1}, 0, 8);
    cyc(8);
  endtask

  task automatic do_ack();
    ack = 1; cyc(1); ack = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    check("R1 valid", byte_valid, 0);
    check("R1 clk_drive", clk_drive_low, 0);
    check("R1 data_drive", data_drive_low, 0);
    rst_n = 1;
    cyc(5);
    check("R1 valid after release", byte_valid, 0);

    for (int v = 0; v < 256; v++) begin
      send_frame(8'(v), v[0]);
      check(v[0] ? "R3 byte" : "R2 byte", byte_out, v);
      check("R2 valid", byte_valid, 1);
      check("R4 clk held", clk_drive_low, 1);
      check("R4 data held", data_drive_low, 1);
      do_ack();
      check("R6 valid cleared", byte_valid, 0);
      check("R6 clk released", clk_drive_low, 0);
      check("R6 data released", data_drive_low, 0);
      cyc(GC + 4);
    end

    send_frame(8'h5A, 0);
    ovr = 1;
    for (int i = 0; i < 40; i++) begin
      ovr_c = i[0]; ovr_d = i[1] ^ i[2]; cyc(3);
    end
    ovr_c = 1; ovr_d = 1; cyc(4); ovr = 0;
    check("R5 byte kept", byte_out, 8'h5A);
    check("R5 valid kept", byte_valid, 1);
    do_ack(); cyc(GC + 4);

    send_bits({1'b0, 8'hC3, 1'b1}, 0, 4);
    do_ack();
    send_bits({1'b0, 8'hC3, 1'b1}, 5, 8);
    cyc(8);
    check("R7 byte after stray ack", byte_out, 8'hC3);
    check("R7 valid", byte_valid, 1);
    do_ack(); cyc(GC + 4);

    send_bits({1'b0, 8'h3C, 1'b1}, 0, 4);
    cyc(TO + 50);
    check("R8 partial dropped", byte_valid, 0);
    send_frame(8'h81, 0);
    check("R8 next byte", byte_out, 8'h81);
    check("R8 valid", byte_valid, 1);

    reset_req = 1; cyc(1); reset_req = 0;
    check("R9 pending cleared", byte_valid, 0);
    begin
      int n = 1, dbad = 0;
      while (clk_drive_low) begin
        if (data_drive_low) dbad++;
        cyc(1);
        if (clk_drive_low) n++;
        if (n > RC + 10) break;
      end
      check("R9 pulse width", n, RC);
      check("R9 data released", dbad, 0);
    end
    cyc(GC + 4);
    send_frame(8'hAA, 0);
    check("R9 self-test byte", byte_out, 8'hAA);
    check("R9 valid", byte_valid, 1);
    do_ack(); cyc(GC + 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule